// File: doc/BRIEF.md
# Source-Selectable Clock Divider with Source-Gated Prescaler

This block derives a divided clock from one of four source clocks, all carried inside a single system clock domain as one-cycle tick enables: a high on `srcEn[i]` marks one rising edge of source i. A 2-bit select field in a 32-bit control register picks the source. Only source 3 passes through a 5-bit prescaler (divide by 1 to 32). Every source then passes through a 2-bit post-divider (divide by 1 to 4). The result appears as a tick stream (`divTick`) and as a level waveform with a defined duty (`divLevel`). A one-cycle `rateValid` strobe marks that a new ratio has taken effect.

Software loads the whole register through a plain write-enable port and reads it back at all times. A second, narrower port rewrites only the two divider fields, so a rate change cannot disturb the source selection or any other bits. Any change of the select or divider fields restarts both counters from zero. The first period at the new ratio is therefore always a full one.

Top module: `clk_src_div`

## Requirements
- R1: While `rstN` is low and after its release, `rdData` is zero (source 0, divide by 1) and `divTick`, `divLevel`, `rateValid` are low until a source tick or a write arrives.
- R2: A write with `wrEn` high stores all 32 bits of `wrData`, and `rdData` shows them from the next cycle. Bits other than [17:16], [12:8] and [5:4] have no effect on the outputs.
- R3: Bits [17:16] select which `srcEn` bit drives the dividers. Ticks on unselected sources never produce `divTick`.
- R4: With post field N in bits [5:4], exactly one `divTick` is produced per N+1 ticks entering the post-divider.
- R5: With select equal to 3, the prescale field P in bits [12:8] divides the source by P+1 ahead of the post-divider. For select 0 to 2, P has no effect.
- R6: A write with `divWrEn` high (and `wrEn` low) replaces only bits [12:8] with `divPre` and bits [5:4] with `divPost`, and keeps every other bit. When both enables are high, the full write wins.
- R7: For a post ratio n of 2 or more, `divLevel` is high for ceil(n/2) and low for floor(n/2) post-divider input ticks per period; it changes the cycle after each such tick. For n = 1, `divLevel` repeats the post-divider input tick one cycle later.
- R8: A write that changes the select, P or N field clears both counters and drops any source tick in that same cycle. The first `divTick` at the new ratio then needs a full (P+1)(N+1) or N+1 ticks.
- R9: `rateValid` is high for exactly the one cycle after a write that changes the select, P or N field. A write that leaves these fields unchanged gives no pulse.
- R10: `divTick` is high in the cycle after the source tick that completes a division period. It never coincides with `rateValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcEn | input | 4 | One-cycle edge ticks of the four source clocks |
| wrEn | input | 1 | Full register write enable |
| wrData | input | 32 | Full register write value |
| divWrEn | input | 1 | Divider-fields-only write enable |
| divPre | input | 5 | New prescale field for a divider-only write |
| divPost | input | 2 | New post-divide field for a divider-only write |
| rdData | output | 32 | Current register value |
| divTick | output | 1 | One tick per divided period |
| divLevel | output | 1 | Divided clock level with defined duty |
| rateValid | output | 1 | One-cycle strobe after a ratio or source change |

## Verification
Directed runs compare the number of `divTick` pulses against the count of entering ticks for several settings. The settings are source 0 at divide by one, source 1 with a full-scale prescale field that must be ignored, and source 3 at the largest combined ratio. Together they separate a prescaler wrongly applied to other sources from one missing on source 3. Random traffic ticks all four sources at once, so only the selected source may count, and it mixes full and divider-only writes, repeated identical writes and simultaneous writes. A cycle-by-cycle model compares `divTick`, `divLevel`, `rateValid` and `rdData` against every ratio, which exposes off-by-one counting, wrong duty on odd ratios, missing counter restarts and field corruption by the narrow write port.

// File: rtl/clk_src_div_pkg.sv
package clk_src_div_pkg;
  localparam int SRC_COUNT = 4;
  localparam int SEL_W     = $clog2(SRC_COUNT);
  localparam int PRE_W     = 5;
  localparam int POST_W    = 2;

  typedef struct packed {
    logic              clearCnt;
    logic [SEL_W-1:0]  sel;
    logic [PRE_W-1:0]  preDiv;
    logic [POST_W-1:0] postDiv;
  } cfgStrobe_t;
endpackage

// File: rtl/clk_src_div_ctrl.sv
module clk_src_div_ctrl
  import clk_src_div_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SEL_LSB  = 16,
  parameter int PRE_LSB  = 8,
  parameter int POST_LSB = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              divWrEn,
  input  logic [PRE_W-1:0]  divPre,
  input  logic [POST_W-1:0] divPost,
  output logic [DATA_W-1:0] ctrlReg,
  output logic              rateValid,
  output cfgStrobe_t        cfg
);
  localparam int SEL_MSB  = SEL_LSB + SEL_W - 1;
  localparam int PRE_MSB  = PRE_LSB + PRE_W - 1;
  localparam int POST_MSB = POST_LSB + POST_W - 1;

  logic [DATA_W-1:0] nextReg;
  logic              fieldChange;

  always_comb begin
    nextReg = ctrlReg;
    if (wrEn) begin
      nextReg = wrData;
    end else if (divWrEn) begin
      nextReg[PRE_MSB:PRE_LSB]   = divPre;
      nextReg[POST_MSB:POST_LSB] = divPost;
    end
  end

  assign fieldChange = (nextReg[SEL_MSB:SEL_LSB]   != ctrlReg[SEL_MSB:SEL_LSB])
                    || (nextReg[PRE_MSB:PRE_LSB]   != ctrlReg[PRE_MSB:PRE_LSB])
                    || (nextReg[POST_MSB:POST_LSB] != ctrlReg[POST_MSB:POST_LSB]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      rateValid <= 1'b0;
    end else begin
      ctrlReg   <= nextReg;
      rateValid <= fieldChange;
    end
  end

  always_comb begin
    cfg.clearCnt = fieldChange;
    cfg.sel      = ctrlReg[SEL_MSB:SEL_LSB];
    cfg.preDiv   = ctrlReg[PRE_MSB:PRE_LSB];
    cfg.postDiv  = ctrlReg[POST_MSB:POST_LSB];
  end

  // R6: narrow write port leaves selection untouched
  a_r6_div_write_keeps_sel: assert property (@(posedge clk) disable iff (!rstN)
    (divWrEn && !wrEn) |=> $stable(ctrlReg[SEL_MSB:SEL_LSB]));

  // R9: strobe only follows an actual change of a functional field
  a_r9_strobe_means_change: assert property (@(posedge clk) disable iff (!rstN)
    rateValid |-> ((ctrlReg[SEL_MSB:SEL_LSB] != $past(ctrlReg[SEL_MSB:SEL_LSB]))
                || (ctrlReg[PRE_MSB:PRE_LSB] != $past(ctrlReg[PRE_MSB:PRE_LSB]))
                || (ctrlReg[POST_MSB:POST_LSB] != $past(ctrlReg[POST_MSB:POST_LSB]))));
endmodule

// File: rtl/clk_src_div_datapath.sv
module clk_src_div_datapath
  import clk_src_div_pkg::*;
#(
  parameter int PRE_SRC = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SRC_COUNT-1:0] srcEn,
  input  cfgStrobe_t           cfg,
  output logic                 divTick,
  output logic                 divLevel
);
  localparam int HALF_W = POST_W + 1;

  logic              selTick;
  logic              usePre;
  logic              preOut;
  logic [PRE_W-1:0]  preCnt;
  logic [POST_W-1:0] postCnt;
  logic [POST_W-1:0] postNext;
  logic [HALF_W-1:0] highSpan;

  assign selTick  = srcEn[cfg.sel];
  assign usePre   = (cfg.sel == SEL_W'(PRE_SRC));
  assign preOut   = usePre ? (selTick && (preCnt == cfg.preDiv)) : selTick;
  assign postNext = (postCnt == cfg.postDiv) ? '0 : postCnt + POST_W'(1);
  assign highSpan = (HALF_W'(cfg.postDiv) + HALF_W'(2)) >> 1;

  always_ff @(posedge clk) begin
    if (!rstN || cfg.clearCnt) begin
      preCnt <= '0;
    end else if (usePre && selTick) begin
      preCnt <= (preCnt == cfg.preDiv) ? '0 : preCnt + PRE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || cfg.clearCnt) begin
      postCnt  <= '0;
      divTick  <= 1'b0;
      divLevel <= 1'b0;
    end else begin
      divTick <= preOut && (postCnt == cfg.postDiv);
      if (cfg.postDiv == '0) begin
        divLevel <= preOut;
      end else if (preOut) begin
        divLevel <= (HALF_W'(postNext) < highSpan);
      end
      if (preOut) begin
        postCnt <= postNext;
      end
    end
  end

  // R4: post counter never passes its limit
  a_r4_post_bound: assert property (@(posedge clk) disable iff (!rstN)
    postCnt <= cfg.postDiv);

  // R5: prescale counter stays within its limit and rests for other sources
  a_r5_pre_bound: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= cfg.preDiv);
  a_r5_pre_idle: assert property (@(posedge clk) disable iff (!rstN)
    !usePre |-> (preCnt == '0));

  // R8: a field change restarts both counters
  a_r8_restart: assert property (@(posedge clk) disable iff (!rstN)
    cfg.clearCnt |=> (preCnt == '0 && postCnt == '0 && !divTick));

  // R10: no output tick without a selected source tick one cycle earlier
  a_r10_tick_needs_source: assert property (@(posedge clk) disable iff (!rstN)
    !selTick |=> !divTick);
endmodule

// File: rtl/clk_src_div.sv
module clk_src_div
  import clk_src_div_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SEL_LSB  = 16,
  parameter int PRE_LSB  = 8,
  parameter int POST_LSB = 4,
  parameter int PRE_SRC  = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SRC_COUNT-1:0] srcEn,
  input  logic                 wrEn,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 divWrEn,
  input  logic [PRE_W-1:0]     divPre,
  input  logic [POST_W-1:0]    divPost,
  output logic [DATA_W-1:0]    rdData,
  output logic                 divTick,
  output logic                 divLevel,
  output logic                 rateValid
);
  cfgStrobe_t cfg;

  clk_src_div_ctrl #(
    .DATA_W(DATA_W), .SEL_LSB(SEL_LSB), .PRE_LSB(PRE_LSB), .POST_LSB(POST_LSB)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .divWrEn(divWrEn), .divPre(divPre), .divPost(divPost),
    .ctrlReg(rdData), .rateValid(rateValid), .cfg(cfg)
  );

  clk_src_div_datapath #(.PRE_SRC(PRE_SRC)) dp_i (
    .clk(clk), .rstN(rstN), .srcEn(srcEn), .cfg(cfg),
    .divTick(divTick), .divLevel(divLevel)
  );

  // R10: restart cycle and output tick are exclusive
  a_r10_no_tick_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    !(divTick && rateValid));
endmodule

// File: tb/clk_src_div_tb.sv
module clk_src_div_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  srcEn;
  logic        wrEn;
  logic [31:0] wrData;
  logic        divWrEn;
  logic [4:0]  divPre;
  logic [1:0]  divPost;
  logic [31:0] rdData;
  logic        divTick, divLevel, rateValid;

  int checks = 0;
  int errors = 0;
  int tickSeen = 0;

  // model state
  logic [31:0] mReg;
  int mPre, mPost;
  logic eTick, eLevel, eValid;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_src_div dut_i (
    .clk(clk), .rstN(rstN), .srcEn(srcEn), .wrEn(wrEn), .wrData(wrData),
    .divWrEn(divWrEn), .divPre(divPre), .divPost(divPost), .rdData(rdData),
    .divTick(divTick), .divLevel(divLevel), .rateValid(rateValid)
  );

  function automatic logic [31:0] mergeDiv(logic [31:0] r, logic [4:0] p, logic [1:0] n);
    logic [31:0] v = r;
    v[12:8] = p;
    v[5:4]  = n;
    return v;
  endfunction

  function automatic logic fieldsDiffer(logic [31:0] a, logic [31:0] b);
    return (a[17:16] != b[17:16]) || (a[12:8] != b[12:8]) || (a[5:4] != b[5:4]);
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model, check after the edge
  task automatic step(input logic [3:0] s, input logic w, input logic [31:0] wd,
                      input logic dw, input logic [4:0] p, input logic [1:0] n);
    logic [31:0] nReg;
    int sel, pLim, nLim, nextPost, half;
    logic selTick, preOut;
    srcEn = s; wrEn = w; wrData = wd; divWrEn = dw; divPre = p; divPost = n;
    nReg = w ? wd : (dw ? mergeDiv(mReg, p, n) : mReg);
    sel = int'(mReg[17:16]); pLim = int'(mReg[12:8]); nLim = int'(mReg[5:4]);
    if (fieldsDiffer(nReg, mReg)) begin
      eTick = 0; eLevel = 0; eValid = 1; mPre = 0; mPost = 0;   // R8 / R9
    end else begin
      eValid = 0;
      selTick = s[sel];
      preOut = selTick;
      if (sel == 3) begin                                       // R5
        preOut = selTick && (mPre == pLim);
        if (selTick) mPre = (mPre == pLim) ? 0 : mPre + 1;
      end
      eTick = preOut && (mPost == nLim);                        // R4 / R10
      nextPost = (mPost == nLim) ? 0 : mPost + 1;
      half = (nLim + 2) / 2;
      if (nLim == 0) eLevel = preOut;                           // R7
      else if (preOut) eLevel = (nextPost < half);
      if (preOut) mPost = nextPost;
    end
    mReg = nReg;
    @(negedge clk);
    if (divTick) tickSeen++;
    check(divTick === eTick, "R10", "divTick", int'(divTick), int'(eTick));
    check(divLevel === eLevel, "R7", "divLevel", int'(divLevel), int'(eLevel));
    check(rateValid === eValid, "R9", "rateValid", int'(rateValid), int'(eValid));
    check(rdData === mReg, "R2/R6", "rdData", int'(rdData), int'(mReg));
  endtask

  task automatic idle(input logic [3:0] s);
    step(s, 1'b0, 32'h0, 1'b0, 5'h0, 2'h0);
  endtask

  task automatic doWrite(input logic [31:0] v);
    step(4'h0, 1'b1, v, 1'b0, 5'h0, 2'h0);
  endtask

  // drive count ticks on one source while others toggle randomly
  task automatic runTicks(input int src, input int count);
    for (int i = 0; i < count; i++) begin
      logic [3:0] s = 4'($urandom);
      s[src] = 1'b1;
      idle(s);
    end
  endtask

  initial begin
    int startTicks;
    void'($urandom(32'd1234));
    mReg = 0; mPre = 0; mPost = 0; eTick = 0; eLevel = 0; eValid = 0;
    rstN = 1'b0; srcEn = 0; wrEn = 0; wrData = 0; divWrEn = 0; divPre = 0; divPost = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rdData === 32'h0, "R1", "rdData in reset", int'(rdData), 0);
    check({divTick, divLevel, rateValid} === 3'b000, "R1", "outputs in reset",
          int'({divTick, divLevel, rateValid}), 0);
    rstN = 1'b1;
    idle(4'h0);

    // R2: full write, other bits read back; R3/R4 pass-through on source 0
    doWrite(32'hA5C0_E0C0);        // sel 0, P 0, N 0, other bits set
    check(!rateValid, "R9", "no strobe for non-functional bits", int'(rateValid), 0);
    startTicks = tickSeen;
    runTicks(0, 10); idle(4'h0);
    check(tickSeen - startTicks == 10, "R3", "source 0 divide by 1",
          tickSeen - startTicks, 10);

    // R5: prescale ignored for source 1, N=1
    doWrite(32'h0001_1F10);
    startTicks = tickSeen;
    runTicks(1, 20); idle(4'h0);
    check(tickSeen - startTicks == 10, "R5", "prescale ignored on source 1",
          tickSeen - startTicks, 10);

    // R5/R4: source 3 at 32*4 = 128
    doWrite(32'h0003_1F30);
    startTicks = tickSeen;
    runTicks(3, 1280); idle(4'h0);
    check(tickSeen - startTicks == 10, "R5", "source 3 divide by 128",
          tickSeen - startTicks, 10);

    // R8: restart after ratio change mid-period, first tick needs full count
    runTicks(3, 50);
    step(4'hF, 1'b0, 32'h0, 1'b1, 5'd2, 2'd1);   // 3*2 = 6
    check(rdData[17:16] == 2'd3, "R6", "select kept on divider write",
          int'(rdData[17:16]), 3);
    startTicks = tickSeen;
    runTicks(3, 5); idle(4'h0);
    check(tickSeen == startTicks, "R8", "no tick before full new period",
          tickSeen - startTicks, 0);
    runTicks(3, 1); idle(4'h0);
    check(tickSeen - startTicks == 1, "R8", "tick after full new period",
          tickSeen - startTicks, 1);

    // R6: both enables, full write wins
    step(4'h0, 1'b1, 32'h0002_0020, 1'b1, 5'd7, 2'd3);
    check(rdData === 32'h0002_0020, "R6", "full write priority", int'(rdData), 32'h0002_0020);

    // R7 odd ratio duty on source 2, N=2
    runTicks(2, 30);

    // random mix
    for (int k = 0; k < 4000; k++) begin
      int r = int'($urandom_range(0, 99));
      logic [31:0] v = $urandom;
      if (r < 3) step(4'($urandom), 1'b1, v, 1'b0, 5'h0, 2'h0);
      else if (r < 5) step(4'($urandom), 1'b1, mReg ^ (v & 32'hFFFC_E0CF), 1'b0, 5'h0, 2'h0);
      else if (r < 8) step(4'($urandom), 1'b0, 32'h0, 1'b1, 5'($urandom), 2'($urandom));
      else if (r < 9) step(4'($urandom), 1'b1, v, 1'b1, 5'($urandom), 2'($urandom));
      else idle(4'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule